// File: doc/BRIEF.md
# LPC I/O Target with Keyboard-Style Host Channels

This block sits on the peripheral side of a Low Pin Count bus. It watches the 4-bit multiplexed LAD lines and the frame strobe, claims I/O read and I/O write cycles whose address belongs to one of its three host channels, and answers with a ready SYNC. Memory, DMA and firmware cycles are ignored, and so are I/O cycles to addresses it does not own. In none of these cases does it drive the bus.

Each channel has a host-written input byte, a host-read output byte and a status byte, with keyboard-controller handshake flags. A local CPU-side register port reaches the same bytes. Two channels answer at fixed address pairs. The third channel sits at a 32-byte aligned base set on an input pin, and it carries sixteen extra bytes that both sides can read and write. A fast A20 gate is decoded straight from host writes. The bus side has no back-pressure: every claimed cycle finishes with a ready SYNC and no wait states. The CPU port is a plain single-cycle register port, so a valid/ready handshake is not used.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle begins on a clock with `lframe_n` low and LAD=0000. The next nibble selects the type: 000x is I/O read and 001x is I/O write. Any other type is ignored, with `lad_oe` held low and no register change.
- R2: Four address nibbles follow the type, most significant first. For a write, two data nibbles follow, low first, then two turnaround clocks. The target then drives 0000 (ready) for one clock and 1111 for one clock, and releases the bus.
- R3: For a read, two turnaround clocks follow the address. The target then drives 0000, the data low nibble, the data high nibble and 1111, one clock each, and releases the bus.
- R4: An I/O cycle to an address owned by no channel is never driven and changes no register.
- R5: A host write to a data address stores the byte in the input register, sets IBF (status bit 1) and clears the command flag (bit 3). A write to a command address stores the byte, sets IBF and sets bit 3.
- R6: A host read of a data address returns the output register and clears OBF (status bit 0). A host read of a command address returns the status byte.
- R7: On the CPU port, channel n (0..2) is at address 2n (read: input register, write: output register) and at 2n+1 (status). A CPU write of the output register sets OBF. A CPU read of the input register clears IBF. Status bits 7:4 and 2 are CPU-writable. The other status bits keep their flag values.
- R8: Channel 0 answers at 0x60 (data) and 0x64 (command). Channel 1 answers at 0x62 and 0x66. Channel 2 answers at base+0 and base+1, where base is `ch3_blk` shifted left by 5.
- R9: Sixteen extra bytes sit at host addresses base+0x10 to base+0x1F and at CPU addresses 0x10 to 0x1F. Either side can read and write them.
- R10: A host command write of 0xD1 to 0x64 arms the A20 gate. The next host data write to 0x60 sets `a20_gate` to data bit 1 and disarms it. Neither of these two writes changes channel 0's registers. Any other command write to 0x64 disarms the gate and is handled normally.
- R11: `lframe_n` low in mid-cycle ends the cycle with no register effect. If LAD is also 0000 on that clock, a new cycle starts.
- R12: After reset, all registers and flags are zero, `a20_gate` is low and `lad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock |
| lreset_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | LAD nibble sampled from the bus |
| lad_out | output | 4 | LAD nibble driven by the target |
| lad_oe | output | 1 | Target drive enable for LAD |
| ch3_blk | input | 11 | Address bits 15:5 of the third channel's base |
| cpu_addr | input | 5 | CPU-side register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (consumes IBF) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from `cpu_addr` |
| a20_gate | output | 1 | Fast A20 gate output |

## Verification
The assertions assume that the host follows the framing rules: a cycle always starts with frame low and LAD=0000, and the host lets go of LAD during the turnaround clocks. They also assume that `ch3_blk` is held steady and that the third channel's block does not overlap the fixed addresses. The bench drives every nibble on the falling edge from tasks that build well-formed cycles, deliberately breaking frames only in the abort and restart scenario. It keeps the channel base at one value that does not overlap, so the bus-ownership properties are only tested against legal traffic.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_TYPE, S_ADDR, S_DLO, S_DHI, S_TAR0, S_TAR1,
    S_SYNC, S_RLO, S_RHI, S_TARB
  } lpc_st_e;

  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] LAD_IDLE   = 4'hF;
  localparam logic [7:0] CMD_A20    = 8'hD1;
  localparam int         ST_OBF     = 0;
  localparam int         ST_IBF     = 1;
  localparam int         ST_CD      = 3;
  localparam logic [7:0] ST_USER    = 8'hF4;
endpackage

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm import lpc_tgt_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic              hit,
  input  logic [7:0]        rdata,
  output logic              wr,
  output logic              rd,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata
);
  localparam int ANIB = ADDR_W / 4;
  localparam int CW   = (ANIB > 1) ? $clog2(ANIB) : 1;

  lpc_st_e       st;
  logic          is_wr;
  logic [CW-1:0] cnt;
  logic [7:0]    rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_wr <= 1'b0;
      cnt   <= '0;
      addr  <= '0;
      wdata <= '0;
      rd_q  <= '0;
    end else if (!lframe_n) begin
      // start or abort: any frame low re-synchronises the machine
      st <= (lad_in == 4'h0) ? S_TYPE : S_IDLE;
    end else begin
      unique case (st)
        S_IDLE: st <= S_IDLE;
        S_TYPE: begin
          is_wr <= lad_in[1];
          cnt   <= '0;
          st    <= (lad_in[3:2] == 2'b00) ? S_ADDR : S_IDLE;
        end
        S_ADDR: begin
          addr <= {addr[ADDR_W-5:0], lad_in};
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(ANIB - 1)) st <= is_wr ? S_DLO : S_TAR0;
        end
        S_DLO: begin wdata[3:0] <= lad_in; st <= S_DHI; end
        S_DHI: begin wdata[7:4] <= lad_in; st <= S_TAR0; end
        S_TAR0: st <= S_TAR1;
        S_TAR1: st <= hit ? S_SYNC : S_IDLE;
        S_SYNC: begin
          if (!is_wr) rd_q <= rdata;
          st <= is_wr ? S_TARB : S_RLO;
        end
        S_RLO:  st <= S_RHI;
        S_RHI:  st <= S_TARB;
        S_TARB: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr = (st == S_SYNC) && is_wr && lframe_n;
  assign rd = (st == S_SYNC) && !is_wr && lframe_n;

  always_comb begin
    lad_oe  = 1'b1;
    lad_out = LAD_IDLE;
    unique case (st)
      S_SYNC: lad_out = SYNC_READY;
      S_RLO:  lad_out = rd_q[3:0];
      S_RHI:  lad_out = rd_q[7:4];
      S_TARB: lad_out = LAD_IDLE;
      default: lad_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpc_tgt_chan.sv
module lpc_tgt_chan import lpc_tgt_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_wr_data,
  input  logic       h_wr_cmd,
  input  logic       h_rd_data,
  input  logic [7:0] h_wdata,
  input  logic       c_wr_odr,
  input  logic       c_wr_sts,
  input  logic       c_rd_idr,
  input  logic [7:0] c_wdata,
  output logic [7:0] idr,
  output logic [7:0] odr,
  output logic [7:0] sts
);
  logic obf, ibf, cd;
  logic [7:0] user;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr <= '0; odr <= '0; obf <= 1'b0; ibf <= 1'b0; cd <= 1'b0; user <= '0;
    end else begin
      if (h_wr_data || h_wr_cmd) begin
        idr <= h_wdata;
        cd  <= h_wr_cmd;
      end
      // set wins over a same-cycle clear
      if (h_wr_data || h_wr_cmd) ibf <= 1'b1;
      else if (c_rd_idr)         ibf <= 1'b0;
      if (c_wr_odr) begin
        odr <= c_wdata;
        obf <= 1'b1;
      end else if (h_rd_data) begin
        obf <= 1'b0;
      end
      if (c_wr_sts) user <= c_wdata & ST_USER;
    end
  end

  always_comb begin
    sts         = user;
    sts[ST_OBF] = obf;
    sts[ST_IBF] = ibf;
    sts[ST_CD]  = cd;
  end
endmodule

// File: rtl/lpc_tgt_a20.sv
module lpc_tgt_a20 import lpc_tgt_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  output logic       eat,
  output logic       a20
);
  logic armed;

  assign eat = (wr_cmd && wdata == CMD_A20) || (wr_data && armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      a20   <= 1'b0;
    end else if (wr_cmd) begin
      armed <= (wdata == CMD_A20);
    end else if (wr_data && armed) begin
      a20   <= wdata[1];
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target import lpc_tgt_pkg::*; #(
  parameter int                ADDR_W   = 16,
  parameter int                XBYTES   = 16,
  parameter logic [ADDR_W-1:0] CH1_DATA = 'h60,
  parameter logic [ADDR_W-1:0] CH1_CMD  = 'h64,
  parameter logic [ADDR_W-1:0] CH2_DATA = 'h62,
  parameter logic [ADDR_W-1:0] CH2_CMD  = 'h66,
  localparam int XB_AW   = $clog2(XBYTES),
  localparam int BLK_LSB = XB_AW + 1,
  localparam int CPU_AW  = XB_AW + 1
) (
  input  logic                      lclk,
  input  logic                      lreset_n,
  input  logic                      lframe_n,
  input  logic [3:0]                lad_in,
  output logic [3:0]                lad_out,
  output logic                      lad_oe,
  input  logic [ADDR_W-BLK_LSB-1:0] ch3_blk,
  input  logic [CPU_AW-1:0]         cpu_addr,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic [7:0]                cpu_wdata,
  output logic [7:0]                cpu_rdata,
  output logic                      a20_gate
);
  localparam int NCH = 3;

  logic              h_wr, h_rd, h_hit, x_hit, a20_eat;
  logic [ADDR_W-1:0] h_addr, ch3_a;
  logic [7:0]        h_wdata, h_rdata;
  logic [ADDR_W-1:0] dat_a [NCH];
  logic [ADDR_W-1:0] cmd_a [NCH];
  logic [NCH-1:0]    hd, hc, eat, c_sel;
  logic [7:0]        idr_q [NCH];
  logic [7:0]        odr_q [NCH];
  logic [7:0]        sts_q [NCH];
  logic [7:0]        xb_q  [XBYTES];
  logic [XB_AW-1:0]  x_idx;

  lpc_tgt_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(lclk), .rst_n(lreset_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .hit(h_hit), .rdata(h_rdata),
    .wr(h_wr), .rd(h_rd), .addr(h_addr), .wdata(h_wdata)
  );

  assign ch3_a    = {ch3_blk, {BLK_LSB{1'b0}}};
  assign dat_a[0] = CH1_DATA;
  assign cmd_a[0] = CH1_CMD;
  assign dat_a[1] = CH2_DATA;
  assign cmd_a[1] = CH2_CMD;
  assign dat_a[2] = ch3_a;
  assign cmd_a[2] = ch3_a | ADDR_W'(1);
  assign x_hit    = (h_addr[ADDR_W-1:XB_AW] == {ch3_blk, 1'b1});
  assign x_idx    = h_addr[XB_AW-1:0];
  assign h_hit    = (|hd) || (|hc) || x_hit;
  assign eat      = {{(NCH-1){1'b0}}, a20_eat};

  lpc_tgt_a20 u_a20 (
    .clk(lclk), .rst_n(lreset_n),
    .wr_cmd(h_wr && hc[0]), .wr_data(h_wr && hd[0]), .wdata(h_wdata),
    .eat(a20_eat), .a20(a20_gate)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hd[i]    = (h_addr == dat_a[i]);
    assign hc[i]    = (h_addr == cmd_a[i]);
    assign c_sel[i] = !cpu_addr[XB_AW] && (cpu_addr[XB_AW-1:1] == (XB_AW-1)'(i));
    lpc_tgt_chan u_ch (
      .clk(lclk), .rst_n(lreset_n),
      .h_wr_data(h_wr && hd[i] && !eat[i]),
      .h_wr_cmd(h_wr && hc[i] && !eat[i]),
      .h_rd_data(h_rd && hd[i]),
      .h_wdata(h_wdata),
      .c_wr_odr(cpu_wr && c_sel[i] && !cpu_addr[0]),
      .c_wr_sts(cpu_wr && c_sel[i] && cpu_addr[0]),
      .c_rd_idr(cpu_rd && c_sel[i] && !cpu_addr[0]),
      .c_wdata(cpu_wdata),
      .idr(idr_q[i]), .odr(odr_q[i]), .sts(sts_q[i])
    );
  end

  // extra bytes of the programmable channel; host side wins a collision
  always_ff @(posedge lclk or negedge lreset_n) begin
    if (!lreset_n) begin
      for (int k = 0; k < XBYTES; k++) xb_q[k] <= '0;
    end else if (h_wr && x_hit) begin
      xb_q[x_idx] <= h_wdata;
    end else if (cpu_wr && cpu_addr[XB_AW]) begin
      xb_q[cpu_addr[XB_AW-1:0]] <= cpu_wdata;
    end
  end

  always_comb begin
    h_rdata = x_hit ? xb_q[x_idx] : 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (hd[i]) h_rdata = odr_q[i];
      if (hc[i]) h_rdata = sts_q[i];
    end
  end

  always_comb begin
    cpu_rdata = cpu_addr[XB_AW] ? xb_q[cpu_addr[XB_AW-1:0]] : 8'h00;
    for (int i = 0; i < NCH; i++)
      if (c_sel[i]) cpu_rdata = cpu_addr[0] ? sts_q[i] : idr_q[i];
  end
endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CH1_DATA = 'h60,
  parameter logic [ADDR_W-1:0] CH2_DATA = 'h62
) (
  input logic              lclk,
  input logic              lreset_n,
  input logic              lframe_n,
  input logic              lad_oe,
  input logic [3:0]        lad_out,
  input logic              a20_gate,
  input logic              h_wr,
  input logic              h_rd,
  input logic [ADDR_W-1:0] h_addr,
  input logic              ibf2,
  input logic              obf2,
  input logic              cpu_wr,
  input logic [4:0]        cpu_addr
);
  // R2 / R3: the first nibble the target drives is always ready
  p_first_drive_sync_r2: assert property (@(posedge lclk) disable iff (!lreset_n)
    $rose(lad_oe) |-> lad_out == 4'h0);

  // R11: a frame strobe always takes the target off the bus next cycle
  p_frame_releases_r11: assert property (@(posedge lclk) disable iff (!lreset_n)
    !lframe_n |=> !lad_oe);

  p_one_strobe_r1: assert property (@(posedge lclk) disable iff (!lreset_n)
    !(h_wr && h_rd));

  // R5: a host data write on the second channel raises IBF
  p_ibf_set_r5: assert property (@(posedge lclk) disable iff (!lreset_n)
    (h_wr && h_addr == CH2_DATA) |=> ibf2);

  // R6: a host data read on the second channel drops OBF unless the CPU refills it
  p_obf_clear_r6: assert property (@(posedge lclk) disable iff (!lreset_n)
    (h_rd && h_addr == CH2_DATA && !(cpu_wr && cpu_addr == 5'd2)) |=> !obf2);

  // R10: the gate moves only after a host write to the first data address
  p_a20_source_r10: assert property (@(posedge lclk) disable iff (!lreset_n)
    !$stable(a20_gate) |-> $past(h_wr && h_addr == CH1_DATA));
endmodule

bind lpc_io_target lpc_io_target_chk #(
  .ADDR_W(ADDR_W), .CH1_DATA(CH1_DATA), .CH2_DATA(CH2_DATA)
) u_chk (
  .lclk(lclk), .lreset_n(lreset_n), .lframe_n(lframe_n),
  .lad_oe(lad_oe), .lad_out(lad_out), .a20_gate(a20_gate),
  .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
  .ibf2(sts_q[1][1]), .obf2(sts_q[1][0]),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr)
);

// File: tb/sim_lpc_io_target.sv
module sim_lpc_io_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [10:0] ch3_blk = 11'h065;   // base 0x0CA0
  logic [4:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        a20_gate;
  int          n_chk = 0, n_err = 0;
  logic        oe_seen = 1'b0;
  logic [7:0]  v;

  always #4 clk = ~clk;

  lpc_io_target u0 (
    .lclk(clk), .lreset_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .ch3_blk(ch3_blk),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .a20_gate(a20_gate)
  );

  always @(negedge clk) if (lad_oe === 1'b1) oe_seen = 1'b1;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic nib(input logic f, input logic [3:0] d);
    @(negedge clk);
    lframe_n = f;
    lad_in   = d;
  endtask

  task automatic cpu_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
    chk(req, "cpu register", d, exp);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d,
                          input bit claim, input string req);
    nib(0, 4'h0); nib(1, 4'h2);
    for (int k = 3; k >= 0; k--) nib(1, a[k*4 +: 4]);
    nib(1, d[3:0]); nib(1, d[7:4]);
    nib(1, 4'hF); nib(1, 4'hF);
    @(negedge clk);
    chk(req, "write sync oe", {7'd0, lad_oe}, {7'd0, claim});
    if (claim) chk("R2", "write sync nibble", {4'd0, lad_out}, 8'h00);
    @(negedge clk);
    chk(req, "write tar oe", {7'd0, lad_oe}, {7'd0, claim});
    if (claim) chk("R2", "write tar nibble", {4'd0, lad_out}, 8'h0F);
    @(negedge clk);
    chk("R2", "write release", {7'd0, lad_oe}, 8'h00);
  endtask

  task automatic io_read(input logic [15:0] a, input bit claim,
                         input string req, output logic [7:0] d);
    logic [3:0] lo;
    nib(0, 4'h0); nib(1, 4'h0);
    for (int k = 3; k >= 0; k--) nib(1, a[k*4 +: 4]);
    nib(1, 4'hF); nib(1, 4'hF);
    @(negedge clk);
    chk(req, "read sync oe", {7'd0, lad_oe}, {7'd0, claim});
    if (claim) chk("R3", "read sync nibble", {4'd0, lad_out}, 8'h00);
    @(negedge clk); lo = lad_out;
    if (claim) chk("R3", "read low oe", {7'd0, lad_oe}, 8'h01);
    @(negedge clk); d = {lad_out, lo};
    @(negedge clk);
    if (claim) chk("R3", "read tar nibble", {3'd0, lad_oe, lad_out}, 8'h1F);
    @(negedge clk);
    chk("R3", "read release", {7'd0, lad_oe}, 8'h00);
  endtask

  task automatic t_reset;
    chk("R12", "oe", {7'd0, lad_oe}, 8'h00);
    chk("R12", "a20", {7'd0, a20_gate}, 8'h00);
    peek(5'd1, 8'h00, "R12");
    peek(5'd0, 8'h00, "R12");
    peek(5'd19, 8'h00, "R12");
  endtask

  task automatic t_host_write;
    io_write(16'h0060, 8'hA5, 1, "R2");
    peek(5'd1, 8'h02, "R5");
    cpu_read(5'd0, v); chk("R5", "data byte", v, 8'hA5);
    peek(5'd1, 8'h00, "R7");
    io_write(16'h0064, 8'h3C, 1, "R8");
    peek(5'd1, 8'h0A, "R5");
    cpu_read(5'd0, v); chk("R5", "command byte", v, 8'h3C);
    peek(5'd1, 8'h08, "R7");
  endtask

  task automatic t_host_read;
    cpu_write(5'd0, 8'h5A);
    peek(5'd1, 8'h09, "R7");
    io_read(16'h0060, 1, "R3", v); chk("R6", "output byte", v, 8'h5A);
    peek(5'd1, 8'h08, "R6");
    cpu_write(5'd1, 8'hFF);
    peek(5'd1, 8'hFC, "R7");
    io_read(16'h0064, 1, "R6", v); chk("R6", "status byte", v, 8'hFC);
    cpu_write(5'd1, 8'h00);
  endtask

  task automatic t_channels;
    io_write(16'h0062, 8'h11, 1, "R8");
    peek(5'd3, 8'h02, "R8");
    peek(5'd1, 8'h08, "R8");
    io_write(16'h0CA1, 8'h77, 1, "R8");
    peek(5'd5, 8'h0A, "R8");
    cpu_read(5'd4, v); chk("R8", "third channel byte", v, 8'h77);
    io_write(16'h0CB3, 8'h9C, 1, "R9");
    peek(5'd19, 8'h9C, "R9");
    cpu_write(5'd31, 8'h42);
    io_read(16'h0CBF, 1, "R9", v); chk("R9", "extra byte read", v, 8'h42);
  endtask

  task automatic t_unclaimed;
    oe_seen = 1'b0;
    io_write(16'h0070, 8'h12, 0, "R4");
    io_read(16'h0061, 0, "R4", v);
    chk("R4", "bus never driven", {7'd0, oe_seen}, 8'h00);
    peek(5'd1, 8'h08, "R4");
    peek(5'd3, 8'h02, "R4");
  endtask

  task automatic t_other_type;
    oe_seen = 1'b0;
    nib(0, 4'h0); nib(1, 4'h4);
    nib(1, 4'h0); nib(1, 4'h0); nib(1, 4'h6); nib(1, 4'h0);
    for (int k = 0; k < 6; k++) nib(1, 4'hF);
    chk("R1", "memory cycle not driven", {7'd0, oe_seen}, 8'h00);
    peek(5'd1, 8'h08, "R1");
  endtask

  task automatic t_a20;
    io_write(16'h0064, 8'hD1, 1, "R10");
    peek(5'd1, 8'h08, "R10");
    io_write(16'h0060, 8'h02, 1, "R10");
    chk("R10", "gate set", {7'd0, a20_gate}, 8'h01);
    peek(5'd1, 8'h08, "R10");
    peek(5'd0, 8'h3C, "R10");
    io_write(16'h0064, 8'hD1, 1, "R10");
    io_write(16'h0064, 8'hAA, 1, "R10");
    peek(5'd1, 8'h0A, "R10");
    cpu_read(5'd0, v);
    io_write(16'h0060, 8'h00, 1, "R10");
    chk("R10", "disarmed gate held", {7'd0, a20_gate}, 8'h01);
    peek(5'd1, 8'h02, "R10");
    cpu_read(5'd0, v); chk("R10", "normal data write", v, 8'h00);
  endtask

  task automatic t_abort;
    oe_seen = 1'b0;
    nib(0, 4'h0); nib(1, 4'h2); nib(1, 4'h0); nib(1, 4'h0);
    nib(0, 4'h5);
    nib(1, 4'h6); nib(1, 4'h0); nib(1, 4'h1); nib(1, 4'h2);
    for (int k = 0; k < 4; k++) nib(1, 4'hF);
    chk("R11", "aborted cycle not driven", {7'd0, oe_seen}, 8'h00);
    peek(5'd1, 8'h00, "R11");
    nib(0, 4'h0); nib(1, 4'h2); nib(1, 4'h0); nib(1, 4'h0);
    io_write(16'h0060, 8'h3E, 1, "R11");
    peek(5'd1, 8'h02, "R11");
    cpu_read(5'd0, v); chk("R11", "restarted write", v, 8'h3E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_host_write;
    t_host_read;
    t_channels;
    t_unclaimed;
    t_other_type;
    t_a20;
    t_abort;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule